// File: doc/BRIEF.md
# DMA Channel Status Tracker

This block holds the status flags of a single DMA channel. It observes the channel's transfer engine (start strobe, read and write bus phases, bus errors, end of each transfer with the live byte count, and arbitration selection) together with the programmed source address, destination address, byte count and transfer size. From these it keeps sticky flags for a configuration fault, a read-side bus error, a write-side bus error and completion. It also shows whether the channel is busy and whether a request is outstanding. All of these appear in one 8-bit status word.

Software clears the sticky flags through a plain byte-wide write strobe. Only bit 0 of the written byte acts. The block also produces a registered acknowledge pulse. A mode pin selects whether that pulse accompanies every externally requested selection or only the last transfer of the block. All pins are control and status signals with no data stream, so no valid/ready handshake applies.

Top module: `dma_chan_status`

## Requirements
- R1: The status word holds DONE in bit 0, BSY in bit 1, REQ in bit 2, BED in bit 4, BES in bit 5 and CE in bit 6. Bits 3 and 7 always read 0. After reset the word is 0x00 and `ack` is 0.
- R2: The size code is 0 for byte, 1 for 16-bit, 2 for 32-bit and 3 for 16-byte line. A start seen while idle is a configuration fault when the byte count is zero, or when the source address, destination address or count has any of its low log2(size) bits set. A fault sets CE and DONE on the next edge and leaves BSY at 0.
- R3: A start seen while idle with a valid configuration sets BSY on the next edge. A start seen while BSY is 1 is ignored.
- R4: While BSY is 1, a `beat_end` pulse with `cur_count` equal to 0 clears BSY and sets DONE on the next edge.
- R5: While BSY is 1, `bus_err` during `rd_phase` sets BES, and during `wr_phase` sets BED. In both cases BSY clears and DONE sets on the next edge.
- R6: A write whose bit 0 is 1 clears DONE, CE, BES and BED together on the next edge. A write whose bit 0 is 0 changes nothing, and written values in the other bits are never taken.
- R7: When a clearing write and a flag-setting event fall in the same cycle, the newly set flag is 1 after the edge, and the other sticky flags are cleared.
- R8: REQ is 1 exactly when BSY will be 1 after the edge and `sel` is 0 in the cycle before. It clears on the edge after the channel is selected.
- R9: With `ack_final_only` at 0, `ack` is 1 in the cycle after any cycle in which BSY is 1, `sel` and `ext_req` are 1, and a read or write phase is active.
- R10: With `ack_final_only` at 1, the same condition also needs `cur_count` to be nonzero and no larger than the byte size of the transfer size latched at the accepted start. This gives `ack` for both the read and the write phase of the final transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe from the transfer engine |
| src_addr | input | ADDR_W | Programmed source address |
| dst_addr | input | ADDR_W | Programmed destination address |
| byte_cnt | input | CNT_W | Programmed byte count |
| xfer_size | input | 2 | Transfer size code (0 byte, 1 16-bit, 2 32-bit, 3 line) |
| sel | input | 1 | Channel chosen by the arbiter this cycle |
| ext_req | input | 1 | Selection is due to an external request |
| rd_phase | input | 1 | Read bus cycle active |
| wr_phase | input | 1 | Write bus cycle active |
| bus_err | input | 1 | Bus error on the active phase |
| beat_end | input | 1 | One transfer finished; `cur_count` is the remaining count |
| cur_count | input | CNT_W | Live byte count from the engine |
| ack_final_only | input | 1 | Acknowledge mode: 0 every selection, 1 final transfer only |
| wr_en | input | 1 | Software write strobe to the status word |
| wr_data | input | 8 | Software write data; only bit 0 acts |
| status | output | 8 | Status word |
| ack | output | 1 | Registered acknowledge |

## Verification
The two functions that can meet in one cycle are the software clear and a hardware flag set: completion, a bus error or a faulty start. The bench makes them collide on purpose. In one directed case a clearing write lands on the same cycle as the final `beat_end`, and the random phase draws writes and engine events independently so that such overlaps recur. Each overlap is judged against a bench model in which the set takes effect after the clear. After the edge, the newly raised flag is expected at 1 and every other sticky flag at 0.

// File: rtl/dst_pkg.sv
package dst_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LINE = 2'd3
  } xfer_sz_e;

  localparam int ST_DONE = 0;
  localparam int ST_BSY  = 1;
  localparam int ST_REQ  = 2;
  localparam int ST_BED  = 4;
  localparam int ST_BES  = 5;
  localparam int ST_CE   = 6;
  localparam int ST_W    = 8;

  // Bytes moved by one transfer of the given size.
  function automatic logic [4:0] sz_bytes(input xfer_sz_e s);
    case (s)
      SZ_BYTE: sz_bytes = 5'd1;
      SZ_HALF: sz_bytes = 5'd2;
      SZ_WORD: sz_bytes = 5'd4;
      default: sz_bytes = 5'd16;
    endcase
  endfunction

  // Low-bit mask that must be clear for the size to be aligned.
  function automatic logic [3:0] sz_mask(input xfer_sz_e s);
    sz_mask = 4'(sz_bytes(s) - 5'd1);
  endfunction

endpackage

// File: rtl/dst_cfg_check.sv
module dst_cfg_check
  import dst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  xfer_sz_e          size,
  output logic              cfg_ok
);
  localparam int N_ADDR = 2;

  logic [ADDR_W-1:0] addr_arr [N_ADDR];
  logic [N_ADDR-1:0] addr_bad;
  logic [ADDR_W-1:0] amask;
  logic [CNT_W-1:0]  cmask;
  logic              cnt_bad;
  logic              cnt_zero;

  assign addr_arr[0] = src_addr;
  assign addr_arr[1] = dst_addr;
  assign amask = ADDR_W'(sz_mask(size));
  assign cmask = CNT_W'(sz_mask(size));

  generate
    for (genvar i = 0; i < N_ADDR; i++) begin : g_addr
      assign addr_bad[i] = |(addr_arr[i] & amask);
    end
  endgenerate

  assign cnt_bad  = |(byte_cnt & cmask);
  assign cnt_zero = (byte_cnt == '0);
  assign cfg_ok   = ~(|addr_bad) & ~cnt_bad & ~cnt_zero;
endmodule

// File: rtl/dst_flag_core.sv
module dst_flag_core
  import dst_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_ok,
  input  logic             sel,
  input  logic             rd_phase,
  input  logic             wr_phase,
  input  logic             bus_err,
  input  logic             beat_end,
  input  logic [CNT_W-1:0] cur_count,
  input  logic             clr,
  output logic             accept,
  output logic [ST_W-1:0]  status
);
  logic done_q, bsy_q, req_q, bed_q, bes_q, ce_q;
  logic start_bad, err_rd, err_wr, fin, stop;
  logic bsy_n;

  assign accept    = start & ~bsy_q & cfg_ok;
  assign start_bad = start & ~bsy_q & ~cfg_ok;
  assign err_rd    = bsy_q & bus_err & rd_phase;
  assign err_wr    = bsy_q & bus_err & wr_phase;
  assign fin       = bsy_q & beat_end & (cur_count == '0);
  assign stop      = err_rd | err_wr | fin;

  always_comb begin
    bsy_n = bsy_q;
    if (accept)    bsy_n = 1'b1;
    else if (stop) bsy_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      bsy_q  <= 1'b0;
      req_q  <= 1'b0;
      bed_q  <= 1'b0;
      bes_q  <= 1'b0;
      ce_q   <= 1'b0;
    end else begin
      bsy_q  <= bsy_n;
      req_q  <= bsy_n & ~sel;
      done_q <= (done_q & ~clr) | stop | start_bad;
      ce_q   <= (ce_q & ~clr) | start_bad;
      bes_q  <= (bes_q & ~clr) | err_rd;
      bed_q  <= (bed_q & ~clr) | err_wr;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_DONE] = done_q;
    status[ST_BSY]  = bsy_q;
    status[ST_REQ]  = req_q;
    status[ST_BED]  = bed_q;
    status[ST_BES]  = bes_q;
    status[ST_CE]   = ce_q;
  end
endmodule

// File: rtl/dst_ack_gen.sv
module dst_ack_gen
  import dst_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             final_only,
  input  logic             active,
  input  logic             sel,
  input  logic             ext_req,
  input  logic             rd_phase,
  input  logic             wr_phase,
  input  logic [CNT_W-1:0] cur_count,
  input  xfer_sz_e         size,
  output logic             ack
);
  logic [CNT_W-1:0] unit;
  logic             last_xfer;
  logic             hit;

  assign unit      = CNT_W'(sz_bytes(size));
  assign last_xfer = (cur_count != '0) && (cur_count <= unit);
  assign hit       = active & sel & ext_req & (rd_phase | wr_phase)
                   & (~final_only | last_xfer);

  always_ff @(posedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= hit;
  end
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [1:0]        xfer_size,
  input  logic              sel,
  input  logic              ext_req,
  input  logic              rd_phase,
  input  logic              wr_phase,
  input  logic              bus_err,
  input  logic              beat_end,
  input  logic [CNT_W-1:0]  cur_count,
  input  logic              ack_final_only,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        status,
  output logic              ack
);
  xfer_sz_e size_in, size_q;
  logic     cfg_ok, accept, clr;
  logic     unused_wr;

  assign size_in   = xfer_sz_e'(xfer_size);
  assign clr       = wr_en & wr_data[ST_DONE];
  assign unused_wr = ^wr_data;

  dst_cfg_check #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .byte_cnt (byte_cnt),
    .size     (size_in),
    .cfg_ok   (cfg_ok)
  );

  dst_flag_core #(.CNT_W(CNT_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_ok    (cfg_ok),
    .sel       (sel),
    .rd_phase  (rd_phase),
    .wr_phase  (wr_phase),
    .bus_err   (bus_err),
    .beat_end  (beat_end),
    .cur_count (cur_count),
    .clr       (clr),
    .accept    (accept),
    .status    (status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      size_q <= SZ_BYTE;
    else if (accept) size_q <= size_in;
  end

  dst_ack_gen #(.CNT_W(CNT_W)) u_ack (
    .clk        (clk),
    .rst_n      (rst_n),
    .final_only (ack_final_only),
    .active     (status[ST_BSY]),
    .sel        (sel),
    .ext_req    (ext_req),
    .rd_phase   (rd_phase),
    .wr_phase   (wr_phase),
    .cur_count  (cur_count),
    .size       (size_q),
    .ack        (ack)
  );
endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       sel,
  input logic       ext_req,
  input logic       rd_phase,
  input logic       wr_phase,
  input logic       bus_err,
  input logic       beat_end,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] status,
  input logic       ack
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] == 1'b0) && (status[7] == 1'b0));

  assert_bus_err_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && bus_err && rd_phase) |=> (status[5] && status[0] && !status[1]));

  assert_bus_err_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && bus_err && wr_phase) |=> (status[4] && status[0] && !status[1]));

  assert_clear_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && !start && !(status[1] && (bus_err || beat_end)))
      |=> (status[6:4] == 3'b000) && !status[0]);

  assert_write_no_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0] && !start && !(status[1] && (bus_err || beat_end)))
      |=> $stable(status[6:4]) && $stable(status[0]));

  assert_req_needs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[1]);

  assert_req_drops_on_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> !status[2]);

  assert_ack_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel && ext_req && (rd_phase || wr_phase))) |=> !ack);
endmodule

bind dma_chan_status dma_chan_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .sel      (sel),
  .ext_req  (ext_req),
  .rd_phase (rd_phase),
  .wr_phase (wr_phase),
  .bus_err  (bus_err),
  .beat_end (beat_end),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .status   (status),
  .ack      (ack)
);

// File: tb/tb_dma_chan_status.sv
module tb_dma_chan_status;
  localparam int AW = 32;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, sel = 0, ext_req = 0, rd_phase = 0, wr_phase = 0;
  logic bus_err = 0, beat_end = 0, mode = 0, wr_en = 0;
  logic [AW-1:0] src_addr = 0, dst_addr = 0;
  logic [CW-1:0] byte_cnt = 0, cur_count = 0;
  logic [1:0] xfer_size = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] status;
  logic ack;

  int vectors = 0;
  int errors = 0;

  // reference state
  logic m_done = 0, m_bsy = 0, m_req = 0, m_bed = 0, m_bes = 0, m_ce = 0, m_ack = 0;
  logic [1:0] m_size = 0;

  always #2 clk = ~clk;

  dma_chan_status #(.ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .dst_addr(dst_addr), .byte_cnt(byte_cnt), .xfer_size(xfer_size),
    .sel(sel), .ext_req(ext_req), .rd_phase(rd_phase), .wr_phase(wr_phase),
    .bus_err(bus_err), .beat_end(beat_end), .cur_count(cur_count),
    .ack_final_only(mode), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .ack(ack)
  );

  function automatic int unit_bytes(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 16;
    endcase
  endfunction

  function automatic logic aligned_ok(input logic [AW-1:0] sa, input logic [AW-1:0] da,
                                      input logic [CW-1:0] bc, input logic [1:0] s);
    int u = unit_bytes(s);
    if (bc == 0) return 1'b0;
    return (sa % u == 0) && (da % u == 0) && (bc % u == 0);
  endfunction

  function automatic logic [7:0] m_status();
    return {1'b0, m_ce, m_bes, m_bed, 1'b0, m_req, m_bsy, m_done};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Apply current inputs for one clock; model predicts, DUT compared after the edge.
  task automatic step();
    logic clr, s_ok, s_bad, e_rd, e_wr, fin, stop, nb, nack;
    int u;
    clr   = wr_en & wr_data[0];
    s_ok  = start & !m_bsy & aligned_ok(src_addr, dst_addr, byte_cnt, xfer_size);
    s_bad = start & !m_bsy & !aligned_ok(src_addr, dst_addr, byte_cnt, xfer_size);
    e_rd  = m_bsy & bus_err & rd_phase;
    e_wr  = m_bsy & bus_err & wr_phase;
    fin   = m_bsy & beat_end & (cur_count == 0);
    stop  = e_rd | e_wr | fin;
    nb    = s_ok ? 1'b1 : (stop ? 1'b0 : m_bsy);
    u     = unit_bytes(m_size);
    nack  = m_bsy & sel & ext_req & (rd_phase | wr_phase) &
            (!mode | ((cur_count != 0) && (int'(cur_count) <= u)));
    @(posedge clk);
    m_req  = nb & !sel;
    m_bsy  = nb;
    m_done = (m_done & !clr) | stop | s_bad;
    m_ce   = (m_ce & !clr) | s_bad;
    m_bes  = (m_bes & !clr) | e_rd;
    m_bed  = (m_bed & !clr) | e_wr;
    m_ack  = nack;
    if (s_ok) m_size = xfer_size;
    @(negedge clk);
    check(status[6] == m_ce,   "R2 CE",   status[6], m_ce);
    check(status[1] == m_bsy,  "R3 BSY",  status[1], m_bsy);
    check(status[0] == m_done, "R4 DONE", status[0], m_done);
    check(status[5:4] == {m_bes, m_bed}, "R5 BES/BED", status[5:4], {m_bes, m_bed});
    check(status[2] == m_req,  "R8 REQ",  status[2], m_req);
    check({status[7], status[3]} == 2'b00, "R1 reserved", status, m_status());
    check(ack == m_ack, mode ? "R10 ack" : "R9 ack", ack, m_ack);
  endtask

  task automatic idle_inputs();
    start = 0; sel = 0; ext_req = 0; rd_phase = 0; wr_phase = 0;
    bus_err = 0; beat_end = 0; wr_en = 0; wr_data = 0;
  endtask

  task automatic do_write(input logic [7:0] d);
    idle_inputs(); wr_en = 1; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic do_start(input logic [AW-1:0] sa, input logic [AW-1:0] da,
                          input logic [CW-1:0] bc, input logic [1:0] s);
    idle_inputs(); start = 1; src_addr = sa; dst_addr = da; byte_cnt = bc;
    xfer_size = s; step(); start = 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(status == 8'h00, "R1 reset status", status, 0);
    check(ack == 1'b0, "R1 reset ack", ack, 0);

    // R2: misaligned source for 32-bit size
    do_start(32'h2, 32'h0, 24'd8, 2'd2);
    check(status == 8'h41, "R2 misaligned start", status, 8'h41);
    // R6: write without bit 0 ignored
    do_write(8'hFE);
    check(status == 8'h41, "R6 write ignored", status, 8'h41);
    do_write(8'h01);
    check(status == 8'h00, "R6 clear", status, 8'h00);
    // R2: zero count
    do_start(32'h0, 32'h0, 24'd0, 2'd0);
    check(status == 8'h41, "R2 zero count", status, 8'h41);
    do_write(8'h01);
    // R2: line size, count not multiple of 16
    do_start(32'h100, 32'h200, 24'd24, 2'd3);
    check(status == 8'h41, "R2 line count misaligned", status, 8'h41);
    do_write(8'h01);

    // R3/R8: valid start, unselected => BSY and REQ
    do_start(32'h10, 32'h20, 24'd8, 2'd2);
    check(status == 8'h06, "R3 R8 busy with request", status, 8'h06);
    idle_inputs(); sel = 1; step();
    check(status == 8'h02, "R8 request cleared on select", status, 8'h02);
    // R3: start while busy ignored, even with bad config
    do_start(32'h1, 32'h0, 24'd0, 2'd2);
    check(status[6] == 1'b0 && status[1], "R3 start while busy", status, 8'h06);

    // R10: final-only acknowledge, dual address
    mode = 1;
    idle_inputs(); sel = 1; ext_req = 1; rd_phase = 1; cur_count = 8; step();
    check(ack == 1'b0, "R10 not final", ack, 0);
    idle_inputs(); sel = 1; ext_req = 1; rd_phase = 1; cur_count = 4; step();
    check(ack == 1'b1, "R10 final read", ack, 1);
    idle_inputs(); sel = 1; ext_req = 1; wr_phase = 1; cur_count = 4; step();
    check(ack == 1'b1, "R10 final write", ack, 1);
    // R7/R4: completion collides with clear
    idle_inputs(); sel = 1; beat_end = 1; cur_count = 0; wr_en = 1; wr_data = 8'h01; step();
    check(status == 8'h01, "R7 R4 set wins over clear", status, 8'h01);
    do_write(8'h01);

    // R9: every-selection acknowledge, then R5 write error
    mode = 0;
    do_start(32'h40, 32'h80, 24'd32, 2'd1);
    idle_inputs(); sel = 1; ext_req = 1; rd_phase = 1; cur_count = 32; step();
    check(ack == 1'b1, "R9 ack on selection", ack, 1);
    idle_inputs(); sel = 1; wr_phase = 1; bus_err = 1; step();
    check(status == 8'h11, "R5 write bus error", status, 8'h11);
    do_write(8'h01);
    do_start(32'h0, 32'h0, 24'd4, 2'd0);
    idle_inputs(); sel = 1; rd_phase = 1; bus_err = 1; step();
    check(status == 8'h21, "R5 read bus error", status, 8'h21);
    do_write(8'h01);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] s;
      int u;
      idle_inputs();
      s = 2'($urandom_range(0, 3));
      u = unit_bytes(s);
      xfer_size = s;
      src_addr = $urandom();
      dst_addr = $urandom();
      byte_cnt = 24'($urandom_range(0, 64));
      if ($urandom_range(0, 3) != 0) begin
        src_addr = src_addr & ~(AW'(u - 1));
        dst_addr = dst_addr & ~(AW'(u - 1));
        byte_cnt = byte_cnt & ~(CW'(u - 1));
      end
      start    = ($urandom_range(0, 7) == 0);
      sel      = $urandom_range(0, 1);
      ext_req  = $urandom_range(0, 1);
      rd_phase = $urandom_range(0, 1);
      wr_phase = !rd_phase && ($urandom_range(0, 1) == 1);
      bus_err  = ($urandom_range(0, 31) == 0);
      beat_end = ($urandom_range(0, 3) == 0);
      cur_count = 24'($urandom_range(0, 20));
      wr_en    = ($urandom_range(0, 7) == 0);
      wr_data  = 8'($urandom());
      if ($urandom_range(0, 99) == 0) mode = ~mode;
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule